// File: doc/BRIEF.md
# Serial Sampling Converter Read Controller

This block is the host side of a three-wire link to a 14-bit serial sampling converter that has no chip select and no command word. It raises the convert line to start a sample, holds it high for the whole internal conversion with the serial clock parked, then drops it, takes the most significant bit straight from the data line and clocks out the remaining bits. Each finished word appears on a parallel output with a one-cycle strobe. While the run enable is held, samples repeat at a period given in system clock cycles.

Power control uses the same two wires. A nap or a sleep request is encoded as a short burst of convert pulses with the serial clock idle. A wake request is a single serial clock pulse. After a sleep, the controller waits a fixed recovery time before it may start another conversion. All timings are parameters counted in system clock cycles. The defaults assume a 200 MHz clock.

Top module: `adc_reader`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, conv, sck, sampleValid and busy are all 0.
- R2: For each conversion, conv stays high for exactly CONV_CYC cycles (260 by default), and sck stays low for that whole time.
- R3: Each read makes exactly DATA_W-1 (13) sck pulses. Each high phase lasts SCK_HALF cycles and each low phase lasts SCK_HALF cycles (5 by default).
- R4: The first sck rise comes exactly SETUP_CYC (2) cycles after conv falls. conv rises no sooner than QUIET_CYC (3) cycles after the last sck fall.
- R5: The word is assembled MSB first. Bit 13 is taken from sdo before the first sck pulse, and each following bit is taken after one sck fall. sdo after the 14th bit has no effect on sample.
- R6: sampleValid is a single-cycle pulse. It occurs only while conv and sck are both low.
- R7: While runEn is held, successive conv rises are max(periodCyc, MIN_PER) cycles apart. MIN_PER is 400 cycles by default (2000 ns).
- R8: A nap request gives 2 conv pulses and a sleep request gives 4. Each pulse is PULSE_CYC (2) cycles high, with no sck edge and no sample.
- R9: A wake request gives exactly one sck pulse. After a nap, the next conversion follows within 10 cycles of that pulse. After a sleep, no conv rise occurs within WAKE_SLEEP_CYC cycles of its falling edge.
- R10: Nap and sleep requests are accepted only when the controller is idle and awake, and wake is accepted only when it is powered down; any other request has no effect. A power request wins over a conversion that falls due in the same cycle, and sleep wins over nap.
- R11: busy is high from the start of a conversion through the quiet time, and throughout power pulses and the sleep recovery wait. busy is low when idle and when powered down. While powered down, runEn starts no conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Keep converting at the programmed period |
| periodCyc | input | PER_W | Requested sample period in clock cycles, clamped up to MIN_PER |
| napReq | input | 1 | Request the light power-down (two convert pulses) |
| sleepReq | input | 1 | Request the deep power-down (four convert pulses) |
| wakeReq | input | 1 | Request wake-up from either power-down |
| sdo | input | 1 | Serial data from the converter |
| conv | output | 1 | Convert line to the converter |
| sck | output | 1 | Serial clock to the converter |
| sample | output | DATA_W | Last captured word |
| sampleValid | output | 1 | One-cycle strobe for a new word |
| busy | output | 1 | Conversion, read, power command or recovery in progress |

## Verification
A power request can reach the idle controller in the same cycle that a conversion falls due. The bench provokes this by leaving the controller idle long enough for the period to lapse, then raising runEn together with a nap request, and later together with both sleep and nap. It judges the outcome at the pins: it expects exactly two (or four) short conv pulses, no sck edge and no new sample. It then expects no conversion at all until a wake request arrives.

// File: rtl/adc_reader_pkg.sv
package adc_reader_pkg;

  // Strobes from the sequencer to the pin/shift datapath
  typedef struct packed {
    logic convLevel;  // level the convert pin takes next cycle
    logic sckLevel;   // level the serial clock takes next cycle
    logic capBit;     // sample sdo at this edge
    logic lastBit;    // this capture completes the word
  } dpCtl_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CONVERT,
    ST_SETUP,
    ST_SCK_HI,
    ST_SCK_LO,
    ST_QUIET,
    ST_PWR_HI,
    ST_PWR_LO,
    ST_DOWN,
    ST_WAKE_HI,
    ST_WAKE_LO,
    ST_WAKE_WAIT
  } ctlState_t;

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_reader_ctl.sv
module adc_reader_ctl
  import adc_reader_pkg::*;
#(
  parameter int unsigned DATA_W         = 14,
  parameter int unsigned PER_W          = 16,
  parameter int unsigned CONV_CYC       = 260,
  parameter int unsigned ACQ_CYC        = 140,
  parameter int unsigned SETUP_CYC      = 2,
  parameter int unsigned SCK_HALF       = 5,
  parameter int unsigned QUIET_CYC      = 3,
  parameter int unsigned PULSE_CYC      = 2,
  parameter int unsigned WAKE_SLEEP_CYC = 220000,
  parameter int unsigned NAP_PULSES     = 2,
  parameter int unsigned SLEEP_PULSES   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [PER_W-1:0] periodCyc,
  input  logic             napReq,
  input  logic             sleepReq,
  input  logic             wakeReq,
  output dpCtl_t           dpCtl,
  output logic             busy
);

  // Shortest period the sequence itself can achieve, and the one the converter needs
  localparam int unsigned READ_CYC = CONV_CYC + SETUP_CYC + (DATA_W - 1) * 2 * SCK_HALF + QUIET_CYC + 1;
  localparam int unsigned MIN_PER  = maxOf(CONV_CYC + ACQ_CYC, READ_CYC);
  localparam int unsigned TMR_MAX  = maxOf(maxOf(maxOf(CONV_CYC, SETUP_CYC), maxOf(SCK_HALF, QUIET_CYC)),
                                           maxOf(PULSE_CYC, WAKE_SLEEP_CYC));
  localparam int unsigned TMR_W    = $clog2(TMR_MAX + 1);
  localparam int unsigned BIT_W    = $clog2(DATA_W);
  localparam int unsigned PLS_W    = $clog2(maxOf(NAP_PULSES, SLEEP_PULSES) + 1);
  localparam logic [PER_W-1:0] MIN_PER_V = PER_W'(MIN_PER);
  localparam logic [PER_W-1:0] PER_SAT   = {PER_W{1'b1}};

  ctlState_t        state, stateN;
  logic [TMR_W-1:0] tmr, tmrN;
  logic [BIT_W-1:0] bitCnt, bitCntN;
  logic [PLS_W-1:0] pulseLeft, pulseLeftN;
  logic             sleepMode, sleepModeN;
  logic [PER_W-1:0] perCnt, perCntN;
  logic [PER_W-1:0] effPeriod;
  logic             tmrDone;
  logic             convDue;

  assign effPeriod = (periodCyc < MIN_PER_V) ? MIN_PER_V : periodCyc;
  assign tmrDone   = (tmr == '0);
  assign convDue   = runEn && (perCnt >= effPeriod);

  always_comb begin
    stateN     = state;
    tmrN       = tmrDone ? tmr : tmr - 1'b1;
    bitCntN    = bitCnt;
    pulseLeftN = pulseLeft;
    sleepModeN = sleepMode;
    perCntN    = (perCnt != PER_SAT) ? perCnt + 1'b1 : perCnt;
    unique case (state)
      ST_IDLE: begin
        if (sleepReq) begin
          stateN     = ST_PWR_HI;
          tmrN       = TMR_W'(PULSE_CYC - 1);
          pulseLeftN = PLS_W'(SLEEP_PULSES - 1);
          sleepModeN = 1'b1;
        end else if (napReq) begin
          stateN     = ST_PWR_HI;
          tmrN       = TMR_W'(PULSE_CYC - 1);
          pulseLeftN = PLS_W'(NAP_PULSES - 1);
          sleepModeN = 1'b0;
        end else if (convDue) begin
          stateN  = ST_CONVERT;
          tmrN    = TMR_W'(CONV_CYC - 1);
          perCntN = PER_W'(1);
        end
      end
      ST_CONVERT: if (tmrDone) begin
        stateN = ST_SETUP;
        tmrN   = TMR_W'(SETUP_CYC - 1);
      end
      ST_SETUP: if (tmrDone) begin
        stateN  = ST_SCK_HI;
        tmrN    = TMR_W'(SCK_HALF - 1);
        bitCntN = BIT_W'(DATA_W - 2);
      end
      ST_SCK_HI: if (tmrDone) begin
        stateN = ST_SCK_LO;
        tmrN   = TMR_W'(SCK_HALF - 1);
      end
      ST_SCK_LO: if (tmrDone) begin
        if (bitCnt == '0) begin
          stateN = ST_QUIET;
          tmrN   = TMR_W'(QUIET_CYC - 1);
        end else begin
          stateN  = ST_SCK_HI;
          tmrN    = TMR_W'(SCK_HALF - 1);
          bitCntN = bitCnt - 1'b1;
        end
      end
      ST_QUIET: if (tmrDone) stateN = ST_IDLE;
      ST_PWR_HI: if (tmrDone) begin
        stateN = ST_PWR_LO;
        tmrN   = TMR_W'(PULSE_CYC - 1);
      end
      ST_PWR_LO: if (tmrDone) begin
        if (pulseLeft == '0) begin
          stateN = ST_DOWN;
        end else begin
          stateN     = ST_PWR_HI;
          tmrN       = TMR_W'(PULSE_CYC - 1);
          pulseLeftN = pulseLeft - 1'b1;
        end
      end
      ST_DOWN: if (wakeReq) begin
        stateN = ST_WAKE_HI;
        tmrN   = TMR_W'(SCK_HALF - 1);
      end
      ST_WAKE_HI: if (tmrDone) begin
        stateN = ST_WAKE_LO;
        tmrN   = TMR_W'(SCK_HALF - 1);
      end
      ST_WAKE_LO: if (tmrDone) begin
        if (sleepMode) begin
          stateN = ST_WAKE_WAIT;
          tmrN   = TMR_W'(WAKE_SLEEP_CYC - 1);
        end else begin
          stateN = ST_IDLE;
        end
      end
      ST_WAKE_WAIT: if (tmrDone) stateN = ST_IDLE;
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tmr       <= '0;
      bitCnt    <= '0;
      pulseLeft <= '0;
      sleepMode <= 1'b0;
      perCnt    <= PER_SAT;
    end else begin
      state     <= stateN;
      tmr       <= tmrN;
      bitCnt    <= bitCntN;
      pulseLeft <= pulseLeftN;
      sleepMode <= sleepModeN;
      perCnt    <= perCntN;
    end
  end

  always_comb begin
    dpCtl.convLevel = (state == ST_CONVERT) || (state == ST_PWR_HI);
    dpCtl.sckLevel  = (state == ST_SCK_HI) || (state == ST_WAKE_HI);
    dpCtl.capBit    = tmrDone && ((state == ST_SETUP) || (state == ST_SCK_LO));
    dpCtl.lastBit   = (state == ST_SCK_LO) && (bitCnt == '0);
  end

  assign busy = (state != ST_IDLE) && (state != ST_DOWN);

  // R10
  wake_when_awake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && wakeReq) |=> (state != ST_WAKE_HI));

  // R10
  no_cmd_midread_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_CONVERT || state == ST_SCK_HI) && (napReq || sleepReq)) |=> (state != ST_PWR_HI));

  // R11
  down_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DOWN && !wakeReq) |=> (state == ST_DOWN));

endmodule

// File: rtl/adc_reader_dp.sv
module adc_reader_dp
  import adc_reader_pkg::*;
#(
  parameter int unsigned DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic              sdo,
  output logic              conv,
  output logic              sck,
  output logic [DATA_W-1:0] sample,
  output logic              sampleValid
);

  logic [DATA_W-2:0] shiftQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      conv        <= 1'b0;
      sck         <= 1'b0;
      shiftQ      <= '0;
      sample      <= '0;
      sampleValid <= 1'b0;
    end else begin
      conv        <= dpCtl.convLevel;
      sck         <= dpCtl.sckLevel;
      sampleValid <= 1'b0;
      if (dpCtl.capBit) begin
        if (dpCtl.lastBit) begin
          sample      <= {shiftQ, sdo};
          sampleValid <= 1'b1;
        end else begin
          shiftQ <= {shiftQ[DATA_W-3:0], sdo};
        end
      end
    end
  end

  // R6
  valid_in_acq_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (!conv && !sck));

endmodule

// File: rtl/adc_reader.sv
module adc_reader
  import adc_reader_pkg::*;
#(
  parameter int unsigned DATA_W         = 14,
  parameter int unsigned PER_W          = 16,
  parameter int unsigned CONV_CYC       = 260,
  parameter int unsigned ACQ_CYC        = 140,
  parameter int unsigned SETUP_CYC      = 2,
  parameter int unsigned SCK_HALF       = 5,
  parameter int unsigned QUIET_CYC      = 3,
  parameter int unsigned PULSE_CYC      = 2,
  parameter int unsigned WAKE_SLEEP_CYC = 220000,
  parameter int unsigned NAP_PULSES     = 2,
  parameter int unsigned SLEEP_PULSES   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic [PER_W-1:0]  periodCyc,
  input  logic              napReq,
  input  logic              sleepReq,
  input  logic              wakeReq,
  input  logic              sdo,
  output logic              conv,
  output logic              sck,
  output logic [DATA_W-1:0] sample,
  output logic              sampleValid,
  output logic              busy
);

  dpCtl_t dpCtl;

  adc_reader_ctl #(
    .DATA_W(DATA_W), .PER_W(PER_W), .CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC),
    .SETUP_CYC(SETUP_CYC), .SCK_HALF(SCK_HALF), .QUIET_CYC(QUIET_CYC),
    .PULSE_CYC(PULSE_CYC), .WAKE_SLEEP_CYC(WAKE_SLEEP_CYC),
    .NAP_PULSES(NAP_PULSES), .SLEEP_PULSES(SLEEP_PULSES)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .periodCyc(periodCyc),
    .napReq(napReq), .sleepReq(sleepReq), .wakeReq(wakeReq),
    .dpCtl(dpCtl), .busy(busy)
  );

  adc_reader_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .sdo(sdo),
    .conv(conv), .sck(sck), .sample(sample), .sampleValid(sampleValid)
  );

  // R2
  sck_parked_chk: assert property (@(posedge clk) disable iff (!rstN)
    conv |-> !sck);

  // R11
  busy_with_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    conv |-> busy);

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rstN) |-> (!conv && !sck && !sampleValid));

endmodule

// File: tb/adc_reader_bench.sv
module adc_reader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MIN_PER    = 400;
  localparam int WAKE_WAIT  = 300;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic [15:0] periodCyc = 16'd500;
  logic        napReq = 1'b0, sleepReq = 1'b0, wakeReq = 1'b0;
  logic        sdo;
  logic        conv, sck, sampleValid, busy;
  logic [13:0] sample;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_reader #(.WAKE_SLEEP_CYC(WAKE_WAIT)) u_adc_reader (
    .clk(clk), .rstN(rstN), .runEn(runEn), .periodCyc(periodCyc),
    .napReq(napReq), .sleepReq(sleepReq), .wakeReq(wakeReq), .sdo(sdo),
    .conv(conv), .sck(sck), .sample(sample), .sampleValid(sampleValid), .busy(busy)
  );

  // Converter model: MSB on conv fall, next bit on each sck fall, then ones
  logic [13:0] slaveWord = 14'h0;
  int slaveIdx = 14;
  always @(negedge conv) slaveIdx = 0;
  always @(negedge sck)  slaveIdx = slaveIdx + 1;
  assign sdo = (slaveIdx < 14) ? slaveWord[13 - slaveIdx] : 1'b1;

  // Pin monitor
  int cyc = 0, riseCnt = 0, validCnt = 0, sckFallCnt = 0;
  int lastRise = 0, riseGap = 0, convLen = 0, fallCyc = 0, quietGap = 0;
  int sckPulses = 0, setupGap = 0, lastSckRise = 0, lastSckFall = 0;
  int sckHighLen = 0, sckLowLen = 0, overlap = 0, convNoBusy = 0, dblValid = 0;
  logic [13:0] lastSample = '0;
  logic pConv = 1'b0, pSck = 1'b0, pValid = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rstN) begin
      if (conv && !pConv) begin
        riseGap  = cyc - lastRise;
        quietGap = cyc - lastSckFall;
        lastRise = cyc;
        sckPulses = 0;
        riseCnt  = riseCnt + 1;
      end
      if (!conv && pConv) begin
        convLen = cyc - lastRise;
        fallCyc = cyc;
      end
      if (sck && !pSck) begin
        if (sckPulses == 0) setupGap = cyc - fallCyc;
        else sckLowLen = cyc - lastSckFall;
        sckPulses = sckPulses + 1;
        lastSckRise = cyc;
      end
      if (!sck && pSck) begin
        sckHighLen = cyc - lastSckRise;
        lastSckFall = cyc;
        sckFallCnt = sckFallCnt + 1;
      end
      if (conv && sck) overlap = overlap + 1;
      if (conv && !busy) convNoBusy = convNoBusy + 1;
      if (sampleValid) begin
        if (pValid) dblValid = dblValid + 1;
        lastSample = sample;
        validCnt = validCnt + 1;
      end
    end
    pConv = conv; pSck = sck; pValid = sampleValid;
  end

  int tests = 0, fails = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulseIn(input bit nap, input bit slp, input bit wk);
    napReq = nap; sleepReq = slp; wakeReq = wk;
    idle(1);
    napReq = 1'b0; sleepReq = 1'b0; wakeReq = 1'b0;
  endtask

  // {period request, word from the converter}
  localparam logic [29:0] VEC_TAB [0:5] = '{
    {16'd500, 14'h2AAA}, {16'd100, 14'h1555}, {16'd400, 14'h3FFF},
    {16'd0,   14'h0000}, {16'd650, 14'h2001}, {16'd401, 14'h1234}
  };

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int r0, f0, v0;
    idle(4);
    // R1 reset state
    check(conv == 0 && sck == 0, "R1", "pins in reset", {conv, sck}, 0);
    check(sampleValid == 0 && busy == 0, "R1", "status in reset", {sampleValid, busy}, 0);
    rstN = 1'b1;
    idle(1);
    check(conv == 0 && sck == 0 && sampleValid == 0, "R1", "first cycle after reset", {conv, sck, sampleValid}, 0);
    runEn = 1'b1;
    wait (riseCnt > 0);
    #1;
    for (int i = 0; i < 6; i++) begin
      int p, eff, r, v;
      p   = int'(VEC_TAB[i][29:14]);
      eff = (p < MIN_PER) ? MIN_PER : p;
      slaveWord = VEC_TAB[i][13:0];
      periodCyc = VEC_TAB[i][29:14];
      r = riseCnt; v = validCnt;
      wait (validCnt > v);
      #1;
      check(lastSample == VEC_TAB[i][13:0], "R5", "captured word", int'(lastSample), int'(VEC_TAB[i][13:0]));
      check(convLen == 260, "R2", "conv high length", convLen, 260);
      check(sckPulses == 13, "R3", "sck pulses per read", sckPulses, 13);
      check(sckHighLen == 5 && sckLowLen == 5, "R3", "sck half periods", sckHighLen * 10 + sckLowLen, 55);
      check(setupGap == 2, "R4", "conv fall to first sck rise", setupGap, 2);
      wait (riseCnt > r);
      #1;
      check(riseGap == eff, "R7", "sample period", riseGap, eff);
      check(quietGap >= 3, "R4", "last sck fall to conv rise", quietGap, 3);
    end

    // Nap request in the same cycle a conversion falls due
    runEn = 1'b0;
    idle(500);
    check(busy == 0, "R11", "busy while idle", busy, 0);
    r0 = riseCnt; f0 = sckFallCnt; v0 = validCnt;
    runEn = 1'b1;
    pulseIn(1'b1, 1'b0, 1'b0);
    idle(300);
    check(riseCnt - r0 == 2, "R8", "nap conv pulses (R10 priority)", riseCnt - r0, 2);
    check(convLen == 2, "R8", "power pulse width", convLen, 2);
    check(sckFallCnt == f0 && validCnt == v0, "R10", "no read after nap", sckFallCnt - f0 + validCnt - v0, 0);
    check(busy == 0, "R11", "busy while napping", busy, 0);
    idle(400);
    check(riseCnt - r0 == 2, "R11", "runEn ignored while down", riseCnt - r0, 2);
    slaveWord = 14'h0F0F;
    f0 = sckFallCnt; v0 = validCnt;
    pulseIn(1'b0, 1'b0, 1'b1);
    idle(30);
    check(sckFallCnt - f0 == 1, "R9", "wake sck pulses", sckFallCnt - f0, 1);
    check(riseCnt - r0 == 3 && lastRise - lastSckFall < 10, "R9", "conversion soon after nap wake", lastRise - lastSckFall, 6);
    wait (validCnt > v0);
    #1;
    check(lastSample == 14'h0F0F, "R5", "word after nap wake", int'(lastSample), 'h0F0F);

    // Sleep and nap together with a due conversion: sleep wins
    runEn = 1'b0;
    idle(500);
    r0 = riseCnt;
    runEn = 1'b1;
    pulseIn(1'b1, 1'b1, 1'b0);
    idle(300);
    check(riseCnt - r0 == 4, "R8", "sleep conv pulses (R10 sleep over nap)", riseCnt - r0, 4);
    f0 = sckFallCnt;
    pulseIn(1'b0, 1'b0, 1'b1);
    idle(100);
    check(sckFallCnt - f0 == 1, "R9", "wake from sleep sck pulses", sckFallCnt - f0, 1);
    check(busy == 1, "R11", "busy during recovery wait", busy, 1);
    check(riseCnt - r0 == 4, "R9", "no conv during recovery", riseCnt - r0, 4);
    wait (riseCnt > r0 + 4);
    #1;
    check(lastRise - lastSckFall >= WAKE_WAIT && lastRise - lastSckFall <= WAKE_WAIT + 10,
          "R9", "recovery wait length", lastRise - lastSckFall, WAKE_WAIT + 6);

    // Wake while awake is ignored
    runEn = 1'b0;
    idle(500);
    f0 = sckFallCnt;
    pulseIn(1'b0, 1'b0, 1'b1);
    idle(50);
    check(sckFallCnt == f0 && busy == 0, "R10", "wake ignored when awake", sckFallCnt - f0, 0);

    // Nap during a conversion is ignored
    runEn = 1'b1;
    r0 = riseCnt;
    wait (riseCnt > r0);
    #1;
    pulseIn(1'b1, 1'b0, 1'b0);
    r0 = riseCnt;
    wait (riseCnt > r0);
    #1;
    check(convLen == 260, "R10", "nap ignored mid-conversion", convLen, 260);
    runEn = 1'b0;
    idle(400);

    check(overlap == 0, "R2", "sck high while conv high", overlap, 0);
    check(dblValid == 0, "R6", "valid longer than one cycle", dblValid, 0);
    check(convNoBusy == 0, "R11", "conv high without busy", convNoBusy, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule